// File: doc/BRIEF.md
# Page-Bounded Serial DMA Pointer Engine

This block is the control side of a two-channel DMA path for a serial controller: one transmit channel and one receive channel. Software programs a pointer register for each channel, then writes the control register to start work. The block derives a physical start address from the pointer and limits the transfer to what remains of the current 4 KB page. It hands a request with address, byte length and direction to a memory-side agent, and waits for that agent to report completion. Moving the data is the agent's job.

Each pointer register holds its address in rotated form. When a transmit transfer completes, the block moves the pointer to the start of the following page, clears its own transmit enable and raises a page-end flag. When a receive transfer completes, the agent reports how many bytes arrived. The block advances the pointer by that amount, keeps receive enabled, and raises a half-page flag each time the 2 KB mark of a page is crossed. Software clears the flags by writing ones to them. Routing the flags to an interrupt controller is left to the surrounding logic.

Top module: `serdma_ptr_engine`

## Requirements
- R1: After reset, every register reads zero and no request is offered (`req_valid` low).
- R2: Register index is (bus_addr − SLOT_BASE)/16, and the low four address bits are ignored. With the default SLOT_BASE of 0x40, the registers are:
  - 0x40: control. Bit 0 is transmit enable and bit 1 is receive enable.
  - 0x50: flags. Bit 0 is transmit page-end and bit 1 is receive half-page.
  - 0x60: transmit pointer.
  - 0x70: receive pointer.
  Offsets below the base, and indices of 4 or more, read as zero and ignore writes.
- R3: The request address is decoded from a pointer P as {P[2:0], P[31:3]}. An address A is stored back as {A[28:2], 2'b00, A[31:29]}.
- R4: The request length is 4096 − (A & 0xFFC), so a request never runs past the end of its 4 KB page.
- R5: Every accepted control write clears the transmit page-end flag. Only after that is a transfer started, so the receive flag is untouched.
- R6: If transmit is enabled but A & 0xFFF is zero, no transmit request is issued and the transmit enable bit stays set.
- R7: When a transmit transfer completes, the page-end flag is set and the transmit enable bit is cleared. The pointer is stored as the next page start, ((A >> 12) + 1) << 12.
- R8: When a receive transfer completes with a count N > 0, the pointer is stored as A + N and the receive enable stays set.
- R9: When a receive transfer completes with N > 0, the half-page flag is set if bit 11 of A differs from bit 11 of A + N.
- R10: When a receive transfer completes with N = 0, the pointer and both flags are left unchanged.
- R11: `req_dir` is 1 for transmit and 0 for receive. When one write enables both channels, the transmit request is issued first and the receive request follows its completion.
- R12: A control write that arrives while a request is outstanding (from launch to done) is ignored entirely.
- R13: Writing the flags register clears each flag whose data bit is 1 and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | OFF_W (8) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| req_valid | output | 1 | Transfer request offered |
| req_ready | input | 1 | Agent accepts the request |
| req_addr | output | 32 | Physical start address |
| req_len | output | PAGE_SHIFT+1 (13) | Byte length |
| req_dir | output | 1 | 1 transmit, 0 receive |
| done | input | 1 | One-cycle completion pulse from the agent |
| done_count | input | PAGE_SHIFT+1 (13) | Bytes received (receive only) |

## Verification
The hardest case to reach from the ports is a control write that lands while a request is outstanding, together with the ordering of two channels started by the same write. The stimulus starts a transmit request and holds the agent's ready low. While the request is still offered, it issues a second control write, then completes the transfer and checks that the second write left no trace. A table of vectors covers the page arithmetic: last word of a page, mid-page, wrap of the top page, a receive count larger than the clipped length, and a zero count. A raw pointer with nonzero low bits checks the rotation directly.

// File: rtl/serdma_pkg.sv
package serdma_pkg;
   localparam int PA_W  = 32;
   localparam int N_REG = 4;

   localparam logic [1:0] IDX_CTRL = 2'd0;
   localparam logic [1:0] IDX_FLAG = 2'd1;
   localparam logic [1:0] IDX_TXP  = 2'd2;
   localparam logic [1:0] IDX_RXP  = 2'd3;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_TX_REQ, SQ_TX_WAIT, SQ_RX_REQ, SQ_RX_WAIT
   } seq_state_t;

   // rotated pointer register -> physical address
   function automatic logic [PA_W-1:0] ptr_to_addr(input logic [PA_W-1:0] r);
      return {r[2:0], r[PA_W-1:3]};
   endfunction

   // physical address -> rotated pointer register
   function automatic logic [PA_W-1:0] addr_to_ptr(input logic [PA_W-1:0] a);
      return {a[28:2], 2'b00, a[31:29]};
   endfunction
endpackage

// File: rtl/serdma_regdec.sv
module serdma_regdec #(
   parameter int OFF_W     = 8,
   parameter int SLOT_BASE = 'h40,
   parameter int N_REGS    = 4,
   localparam int IDX_W    = $clog2(N_REGS)
) (
   input  logic             bus_wr,
   input  logic [OFF_W-1:0] bus_addr,
   output logic             hit,
   output logic [IDX_W-1:0] idx,
   output logic [N_REGS-1:0] wr_strb
);
   localparam logic [OFF_W-1:0] BASE_V = OFF_W'(SLOT_BASE);
   localparam logic [OFF_W-5:0] NREG_V = (OFF_W-4)'(N_REGS);

   logic [OFF_W-1:0] rel;
   logic [OFF_W-5:0] slot;
   logic [3:0]       unused_low;

   assign rel        = bus_addr - BASE_V;
   assign slot       = rel[OFF_W-1:4];
   assign unused_low = rel[3:0];
   assign hit        = (bus_addr >= BASE_V) && (slot < NREG_V);
   assign idx        = slot[IDX_W-1:0];

   for (genvar g = 0; g < N_REGS; g++) begin : g_strb
      assign wr_strb[g] = bus_wr && hit && (idx == IDX_W'(g));
   end

   initial begin
      base_align_chk : assert (SLOT_BASE % 16 == 0)
         else $error("SLOT_BASE must sit on a 16-byte boundary");
      width_chk : assert (OFF_W >= IDX_W + 5)
         else $error("OFF_W too narrow for the register window");
   end
endmodule

// File: rtl/serdma_chan_calc.sv
module serdma_chan_calc
   import serdma_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   parameter int IS_TX      = 1,
   localparam int CNT_W     = PAGE_SHIFT + 1
) (
   input  logic [PA_W-1:0]  ptr_reg,
   input  logic [CNT_W-1:0] count,
   output logic [PA_W-1:0]  addr,
   output logic [CNT_W-1:0] len,
   output logic             launch_ok,
   output logic [PA_W-1:0]  next_ptr,
   output logic             half_cross,
   output logic             do_update
);
   localparam logic [CNT_W-1:0] PAGE_BYTES = {1'b1, {PAGE_SHIFT{1'b0}}};

   logic [PA_W-1:0]  nxt_addr;
   logic [CNT_W-1:0] page_off;

   assign addr     = ptr_to_addr(ptr_reg);
   assign page_off = {1'b0, addr[PAGE_SHIFT-1:2], 2'b00};
   assign len      = PAGE_BYTES - page_off;
   assign next_ptr = addr_to_ptr(nxt_addr);

   if (IS_TX != 0) begin : g_tx
      logic unused_cnt;
      assign unused_cnt = ^count;
      assign launch_ok  = |addr[PAGE_SHIFT-1:0];
      assign nxt_addr   = {addr[PA_W-1:PAGE_SHIFT]
                           + {{(PA_W-PAGE_SHIFT-1){1'b0}}, 1'b1},
                           {PAGE_SHIFT{1'b0}}};
      assign half_cross = 1'b0;
      assign do_update  = 1'b1;
   end else begin : g_rx
      assign launch_ok  = 1'b1;
      assign nxt_addr   = addr + {{(PA_W-CNT_W){1'b0}}, count};
      assign half_cross = addr[PAGE_SHIFT-1] ^ nxt_addr[PAGE_SHIFT-1];
      assign do_update  = |count;
   end
endmodule

// File: rtl/serdma_seq.sv
module serdma_seq
   import serdma_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   localparam int CNT_W     = PAGE_SHIFT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic             ctrl_tx,
   input  logic             ctrl_rx,
   input  logic             tx_ok,
   input  logic [PA_W-1:0]  tx_addr,
   input  logic [CNT_W-1:0] tx_len,
   input  logic [PA_W-1:0]  rx_addr,
   input  logic [CNT_W-1:0] rx_len,
   input  logic             req_ready,
   input  logic             done,
   output logic             req_valid,
   output logic [PA_W-1:0]  req_addr,
   output logic [CNT_W-1:0] req_len,
   output logic             req_dir,
   output logic             busy,
   output logic             tx_done,
   output logic             rx_done
);
   localparam logic [CNT_W-1:0] PAGE_BYTES = {1'b1, {PAGE_SHIFT{1'b0}}};

   seq_state_t state;
   logic       rx_pend;

   assign req_valid = (state == SQ_TX_REQ) || (state == SQ_RX_REQ);
   assign busy      = (state != SQ_IDLE);
   assign tx_done   = (state == SQ_TX_WAIT) && done;
   assign rx_done   = (state == SQ_RX_WAIT) && done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         rx_pend  <= 1'b0;
         req_addr <= '0;
         req_len  <= '0;
         req_dir  <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (ctrl_wr) begin
                  if (ctrl_tx && tx_ok) begin
                     state    <= SQ_TX_REQ;
                     rx_pend  <= ctrl_rx;
                     req_addr <= tx_addr;
                     req_len  <= tx_len;
                     req_dir  <= 1'b1;
                  end else if (ctrl_rx) begin
                     state    <= SQ_RX_REQ;
                     rx_pend  <= 1'b0;
                     req_addr <= rx_addr;
                     req_len  <= rx_len;
                     req_dir  <= 1'b0;
                  end
               end
            end
            SQ_TX_REQ:  if (req_ready) state <= SQ_TX_WAIT;
            SQ_TX_WAIT: begin
               if (done) begin
                  if (rx_pend) begin
                     state    <= SQ_RX_REQ;
                     req_addr <= rx_addr;
                     req_len  <= rx_len;
                     req_dir  <= 1'b0;
                  end else begin
                     state <= SQ_IDLE;
                  end
                  rx_pend <= 1'b0;
               end
            end
            SQ_RX_REQ:  if (req_ready) state <= SQ_RX_WAIT;
            SQ_RX_WAIT: if (done) state <= SQ_IDLE;
            default:    state <= SQ_IDLE;
         endcase
      end
   end

   // R4
   page_bound_chk : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({1'b0, req_addr[PAGE_SHIFT-1:2], 2'b00} + req_len) == PAGE_BYTES);

   // R11
   req_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_len) && $stable(req_dir)));

   // R11
   rx_follows_tx_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && rx_pend) |=> (req_valid && !req_dir));
endmodule

// File: rtl/serdma_ptr_engine.sv
module serdma_ptr_engine
   import serdma_pkg::*;
#(
   parameter int OFF_W      = 8,
   parameter int SLOT_BASE  = 'h40,
   parameter int PAGE_SHIFT = 12,
   localparam int CNT_W     = PAGE_SHIFT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [OFF_W-1:0] bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [31:0]      req_addr,
   output logic [CNT_W-1:0] req_len,
   output logic             req_dir,
   input  logic             done,
   input  logic [CNT_W-1:0] done_count
);
   localparam int IDX_W = $clog2(N_REG);

   logic [1:0]       ctrl_q, ctrl_d;
   logic [1:0]       flag_q, flag_d;
   logic [PA_W-1:0]  ptr_q [2];
   logic [PA_W-1:0]  ptr_d [2];

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [N_REG-1:0] wr_strb;

   logic [PA_W-1:0]  ch_addr [2];
   logic [CNT_W-1:0] ch_len  [2];
   logic             ch_ok   [2];
   logic [PA_W-1:0]  ch_next [2];
   logic             ch_half [2];
   logic             ch_upd  [2];

   logic busy, tx_done, rx_done, ctrl_wr_ok;
   logic unused_tx;

   initial begin
      page_range_chk : assert (PAGE_SHIFT >= 4 && PAGE_SHIFT <= 20)
         else $error("PAGE_SHIFT out of range");
   end

   serdma_regdec #(.OFF_W(OFF_W), .SLOT_BASE(SLOT_BASE), .N_REGS(N_REG)) u_dec (
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .hit     (hit),
      .idx     (idx),
      .wr_strb (wr_strb)
   );

   for (genvar c = 0; c < 2; c++) begin : g_chan
      serdma_chan_calc #(.PAGE_SHIFT(PAGE_SHIFT), .IS_TX((c == 0) ? 1 : 0)) u_calc (
         .ptr_reg   (ptr_q[c]),
         .count     (done_count),
         .addr      (ch_addr[c]),
         .len       (ch_len[c]),
         .launch_ok (ch_ok[c]),
         .next_ptr  (ch_next[c]),
         .half_cross(ch_half[c]),
         .do_update (ch_upd[c])
      );
   end

   assign unused_tx  = ch_half[0] ^ ch_upd[0] ^ ch_ok[1];
   assign ctrl_wr_ok = wr_strb[IDX_CTRL] && !busy;

   serdma_seq #(.PAGE_SHIFT(PAGE_SHIFT)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr_ok),
      .ctrl_tx  (bus_wdata[0]),
      .ctrl_rx  (bus_wdata[1]),
      .tx_ok    (ch_ok[0]),
      .tx_addr  (ch_addr[0]),
      .tx_len   (ch_len[0]),
      .rx_addr  (ch_addr[1]),
      .rx_len   (ch_len[1]),
      .req_ready(req_ready),
      .done     (done),
      .req_valid(req_valid),
      .req_addr (req_addr),
      .req_len  (req_len),
      .req_dir  (req_dir),
      .busy     (busy),
      .tx_done  (tx_done),
      .rx_done  (rx_done)
   );

   always_comb begin
      ctrl_d   = ctrl_q;
      flag_d   = flag_q;
      ptr_d[0] = ptr_q[0];
      ptr_d[1] = ptr_q[1];
      if (wr_strb[IDX_FLAG]) flag_d = flag_q & ~bus_wdata[1:0];
      if (wr_strb[IDX_TXP])  ptr_d[0] = bus_wdata;
      if (wr_strb[IDX_RXP])  ptr_d[1] = bus_wdata;
      if (ctrl_wr_ok) begin
         ctrl_d    = bus_wdata[1:0];
         flag_d[0] = 1'b0;
      end
      if (tx_done) begin
         ctrl_d[0] = 1'b0;
         flag_d[0] = 1'b1;
         ptr_d[0]  = ch_next[0];
      end
      if (rx_done && ch_upd[1]) begin
         ptr_d[1] = ch_next[1];
         if (ch_half[1]) flag_d[1] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         flag_q   <= '0;
         ptr_q[0] <= '0;
         ptr_q[1] <= '0;
      end else begin
         ctrl_q   <= ctrl_d;
         flag_q   <= flag_d;
         ptr_q[0] <= ptr_d[0];
         ptr_q[1] <= ptr_d[1];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (idx)
            IDX_CTRL: bus_rdata = {30'd0, ctrl_q};
            IDX_FLAG: bus_rdata = {30'd0, flag_q};
            IDX_TXP:  bus_rdata = ptr_q[0];
            default:  bus_rdata = ptr_q[1];
         endcase
      end
   end

   // R7
   tx_finish_chk : assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> (!ctrl_q[0] && flag_q[0]));

   // R10
   rx_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && done_count == '0 && !bus_wr) |=> ($stable(ptr_q[1]) && $stable(flag_q)));

   // R12
   busy_ignore_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strb[IDX_CTRL] && busy && !tx_done) |=> $stable(ctrl_q));

   // R8
   rx_keep_en_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !bus_wr) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_serdma_ptr_engine.sv
module tb_serdma_ptr_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr;
   logic [12:0] req_len;
   logic        req_dir;
   logic        done = 1'b0;
   logic [12:0] done_count = '0;

   int errs = 0;
   int checks = 0;
   bit finished = 1'b0;

   localparam logic [7:0] A_CTRL = 8'h40, A_FLAG = 8'h50, A_TXP = 8'h60, A_RXP = 8'h70;

   localparam int NV = 9;
   localparam bit          V_TX  [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0};
   localparam logic [31:0] V_A   [NV] = '{32'h0000_1004, 32'hA000_0FFC, 32'h1234_5800,
                                          32'hFFFF_F010, 32'h0000_37F0, 32'h0000_3810,
                                          32'h8000_0000, 32'h0000_5400, 32'h0000_2FFC};
   localparam logic [12:0] V_CNT [NV] = '{13'd0, 13'd0, 13'd0, 13'd0, 13'h020, 13'h010,
                                          13'h1000, 13'h000, 13'h008};

   always #4 clk = ~clk;

   serdma_ptr_engine dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
      .req_dir(req_dir), .done(done), .done_count(done_count)
   );

   function automatic logic [31:0] enc(input logic [31:0] a);
      return {a[28:2], 2'b00, a[31:29]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic serve(input string tag, input logic dir, input logic [31:0] a,
                        input logic [12:0] len, input logic [12:0] cnt);
      int n = 0;
      while (!req_valid && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " valid"}, {31'd0, req_valid}, 32'd1);
      chk({tag, " dir"},   {31'd0, req_dir},   {31'd0, dir});
      chk({tag, " addr"},  req_addr, a);
      chk({tag, " len"},   {19'd0, req_len}, {19'd0, len});
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      done = 1'b1; done_count = cnt;
      @(negedge clk);
      done = 1'b0; done_count = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d, a, n_a, e_ptr;
      logic [12:0] e_len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, d); chk("R1 ctrl", d, 0);
      rd(A_FLAG, d); chk("R1 flag", d, 0);
      rd(A_TXP, d);  chk("R1 txp", d, 0);
      rd(A_RXP, d);  chk("R1 rxp", d, 0);
      chk("R1 req_valid", {31'd0, req_valid}, 0);

      // vector table: R3 R4 R7 R8 R9 R10 R11
      for (int i = 0; i < NV; i++) begin
         a = V_A[i];
         e_len = 13'h1000 - {1'b0, a[11:2], 2'b00};
         wr(A_FLAG, 32'h3);
         wr(V_TX[i] ? A_TXP : A_RXP, enc(a));
         wr(A_CTRL, V_TX[i] ? 32'h1 : 32'h2);
         serve($sformatf("R3/R4/R11 v%0d", i), V_TX[i], a, e_len, V_CNT[i]);
         if (V_TX[i]) begin
            n_a = {a[31:12] + 20'd1, 12'h000};
            rd(A_TXP, d);  chk($sformatf("R7 ptr v%0d", i), d, enc(n_a));
            rd(A_FLAG, d); chk($sformatf("R7 flag v%0d", i), d, 32'h1);
            rd(A_CTRL, d); chk($sformatf("R7 ctrl v%0d", i), d, 32'h0);
         end else begin
            n_a = a + {19'd0, V_CNT[i]};
            e_ptr = (V_CNT[i] != 0) ? enc(n_a) : enc(a);
            rd(A_RXP, d);  chk($sformatf("R8/R10 ptr v%0d", i), d, e_ptr);
            rd(A_FLAG, d);
            chk($sformatf("R9/R10 flag v%0d", i), d,
                {30'd0, (V_CNT[i] != 0) && (a[11] != n_a[11]), 1'b0});
            rd(A_CTRL, d); chk($sformatf("R8 ctrl v%0d", i), d, 32'h2);
         end
      end

      // R6: transmit with zero page offset issues nothing
      wr(A_CTRL, 0);
      wr(A_TXP, enc(32'h0000_3000));
      wr(A_CTRL, 32'h1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R6 no request", {31'd0, req_valid}, 0);
      end
      rd(A_CTRL, d); chk("R6 enable kept", d, 32'h1);

      // R6 + R11: both enabled, transmit skipped, receive still runs
      wr(A_RXP, enc(32'h0000_0100));
      wr(A_CTRL, 32'h3);
      serve("R6/R11 rx after skip", 1'b0, 32'h0000_0100, 13'h0F00, 13'h0);

      // R11: both enabled, transmit first then receive
      wr(A_FLAG, 32'h3);
      wr(A_TXP, enc(32'h0000_4F00));
      wr(A_RXP, enc(32'h0000_67F8));
      wr(A_CTRL, 32'h3);
      serve("R11 first tx", 1'b1, 32'h0000_4F00, 13'h0100, 13'h0);
      serve("R11 then rx", 1'b0, 32'h0000_67F8, 13'h0808, 13'h010);
      rd(A_FLAG, d); chk("R11 both flags", d, 32'h3);
      rd(A_CTRL, d); chk("R11 ctrl", d, 32'h2);

      // R5: control write clears only transmit page-end flag
      wr(A_CTRL, 32'h0);
      rd(A_FLAG, d); chk("R5 tx flag cleared", d, 32'h2);

      // R13: write-one-to-clear
      wr(A_FLAG, 32'h0);
      rd(A_FLAG, d); chk("R13 zero write", d, 32'h2);
      wr(A_FLAG, 32'h2);
      rd(A_FLAG, d); chk("R13 clear rx", d, 32'h0);

      // R12: control write during outstanding request ignored
      wr(A_TXP, enc(32'h0000_7800));
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h2);
      rd(A_CTRL, d); chk("R12 ctrl held", d, 32'h1);
      serve("R12 tx", 1'b1, 32'h0000_7800, 13'h0800, 13'h0);
      rd(A_CTRL, d); chk("R12 ctrl after", d, 32'h0);
      @(negedge clk);
      chk("R12 no rx follows", {31'd0, req_valid}, 0);

      // R2 + R3: raw rotated pointer via unaligned offset
      wr(8'h74, 32'h0000_8005);
      wr(A_CTRL, 32'h2);
      serve("R2/R3 raw decode", 1'b0, 32'hA000_1000, 13'h1000, 13'h0);
      rd(A_RXP, d); chk("R2 rxp raw kept", d, 32'h0000_8005);

      // R2: out-of-window accesses
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h90, 32'hFFFF_FFFF);
      rd(8'h30, d); chk("R2 below base", d, 0);
      rd(8'h90, d); chk("R2 beyond map", d, 0);
      rd(A_TXP, d); chk("R2 txp untouched", d, enc(32'h0000_8000));
      rd(A_CTRL, d); chk("R2 ctrl untouched", d, 32'h2);

      finish_run();
   end
endmodule